// File: doc/BRIEF.md
# Serial link power state controller

This block owns the per-port link command field of a serial storage port and turns software writes into power transition requests toward the link layer. Software writes a 4-bit command requesting the active, partial or slumber state. The block holds that request on a request/acknowledge/reject handshake until the link answers. It tracks the resulting link state, and clears the command field back to idle by itself. While a command is in progress the field reads non-zero and further command writes are dropped.

With the aggressive enable bit set, the block watches the command-issue and active-tag vectors of the port. When both fall to empty, it asks for a low-power state by itself. The select bit picks partial or slumber as the target. This happens only once per idle event, and only while the link is active.

Top module: `lps_ctrl`

## Requirements
- R1: After reset, the command field reads 0h, the link state reads active (00b), no request is raised, and both the aggressive enable and select bits read 0.
- R2: A write of 1h (active), 2h (partial) or 6h (slumber) while the field reads 0h, naming a state other than the current one, shows the written value on the field from the next cycle. In that cycle a request is raised with target 00b (active), 01b (partial) or 10b (slumber).
- R3: A raised request and its target stay unchanged until the link acknowledges or rejects it.
- R4: One cycle after an acknowledge of a raised request, the link state equals the requested target, the field reads 0h and the request is low.
- R5: One cycle after a reject, the field reads 0h, the request is low and the link state is unchanged.
- R6: A write requesting the state the link is already in raises no request, and the field reads 0h in the next cycle.
- R7: Writes of the reserved values 3h, 4h, 5h and 7h to Fh raise no request and leave the field at 0h.
- R8: Command writes arriving while the field reads non-zero are ignored. The request, its target and the field are unchanged. The aggressive enable and select bits are updated by every write.
- R9: With aggressive enable set, the link active and the field at 0h, the cycle in which the OR of all command-issue and active-tag bits falls from 1 to 0 loads the field with 6h when select is 1, or 2h when select is 0. It also raises the matching request.
- R10: With aggressive enable clear, the issue and tag vectors going empty raise no request.
- R11: Automatic entry fires at most once per fall to empty. It does not fire while the link is not active. In a cycle that also accepts a software command, the software command wins.
- R12: A write of 1h while the link is in partial or slumber is forwarded as a request with target active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_cmd_i | input | 4 | Command field write value |
| wr_aggr_en_i | input | 1 | Aggressive entry enable write value |
| wr_aggr_sel_i | input | 1 | Aggressive target select write value (1 slumber, 0 partial) |
| cmd_o | output | 4 | Command field read value |
| aggr_en_o | output | 1 | Aggressive enable read value |
| aggr_sel_o | output | 1 | Aggressive select read value |
| issue_i | input | SLOTS | Command-issue vector |
| tags_i | input | SLOTS | Active-tag vector |
| link_req_o | output | 1 | Power transition request to the link |
| link_req_state_o | output | 2 | Requested target state |
| link_ack_i | input | 1 | Link accepted the request |
| link_nak_i | input | 1 | Link rejected the request |
| link_state_o | output | 2 | Current link state (00 active, 01 partial, 10 slumber) |

## Verification
The bench builds the block with SLOTS=4. This keeps the issue and tag vectors narrow enough to drive activity on either one alone, or on both, and to let the last active bit drop from each side. It walks the link through active, partial and slumber and back. It covers accepted and rejected requests, same-state, reserved and overlapping writes, and automatic entry with both select values, both enable values, and in a cycle that also carries a software write.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'd0,
    LS_PARTIAL = 2'd1,
    LS_SLUMBER = 2'd2
  } link_st_e;

  localparam int unsigned CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_IDLE    = 4'h0;
  localparam logic [CMD_W-1:0] CMD_ACTIVE  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_PARTIAL = 4'h2;
  localparam logic [CMD_W-1:0] CMD_SLUMBER = 4'h6;

  function automatic logic [CMD_W-1:0] cmd_of(link_st_e s);
    case (s)
      LS_PARTIAL: cmd_of = CMD_PARTIAL;
      LS_SLUMBER: cmd_of = CMD_SLUMBER;
      default:    cmd_of = CMD_ACTIVE;
    endcase
  endfunction
endpackage

// File: rtl/lps_cmd_decode.sv
module lps_cmd_decode
  import lps_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output logic             valid_o,
  output link_st_e         target_o
);
  always_comb begin
    valid_o  = 1'b1;
    target_o = LS_ACTIVE;
    case (cmd_i)
      CMD_ACTIVE:  target_o = LS_ACTIVE;
      CMD_PARTIAL: target_o = LS_PARTIAL;
      CMD_SLUMBER: target_o = LS_SLUMBER;
      default:     valid_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/lps_idle_detect.sv
module lps_idle_detect #(
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] issue_i,
  input  logic [SLOTS-1:0] tags_i,
  output logic             idle_fall_o
);
  logic busy, busy_q;

  assign busy = (|issue_i) | (|tags_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy;
  end

  // one pulse per busy->empty transition
  assign idle_fall_o = busy_q & ~busy;

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_fall_o |=> !idle_fall_o);
endmodule

// File: rtl/lps_link_fsm.sv
module lps_link_fsm
  import lps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  link_st_e         go_target_i,
  input  logic             ack_i,
  input  logic             nak_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             req_o,
  output link_st_e         req_state_o,
  output link_st_e         state_o
);
  logic [CMD_W-1:0] cmd_q;
  link_st_e         tgt_q, st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_IDLE;
      tgt_q <= LS_ACTIVE;
      st_q  <= LS_ACTIVE;
    end else if (cmd_q != CMD_IDLE) begin
      if (ack_i) begin
        st_q  <= tgt_q;
        cmd_q <= CMD_IDLE;
      end else if (nak_i) begin
        cmd_q <= CMD_IDLE;
      end
    end else if (go_i) begin
      cmd_q <= cmd_of(go_target_i);
      tgt_q <= go_target_i;
    end
  end

  assign cmd_o       = cmd_q;
  assign req_o       = (cmd_q != CMD_IDLE);
  assign req_state_o = tgt_q;
  assign state_o     = st_q;

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !nak_i) |=> (req_o && $stable(req_state_o)));
  a_r4_ack_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (state_o == $past(req_state_o) && cmd_o == CMD_IDLE));
  a_r5_nak_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && nak_i) |=> ($stable(state_o) && cmd_o == CMD_IDLE));
  a_r4_state_on_ack_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> $past(ack_i));
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_cmd_i,
  input  logic             wr_aggr_en_i,
  input  logic             wr_aggr_sel_i,
  output logic [3:0]       cmd_o,
  output logic             aggr_en_o,
  output logic             aggr_sel_o,
  input  logic [SLOTS-1:0] issue_i,
  input  logic [SLOTS-1:0] tags_i,
  output logic             link_req_o,
  output logic [1:0]       link_req_state_o,
  input  logic             link_ack_i,
  input  logic             link_nak_i,
  output logic [1:0]       link_state_o
);
  logic     aen_q, asel_q;
  logic     sw_valid, idle_fall, sw_go, auto_go, go;
  link_st_e sw_target, auto_target, go_target, req_st, cur_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aen_q  <= 1'b0;
      asel_q <= 1'b0;
    end else if (wr_en_i) begin
      aen_q  <= wr_aggr_en_i;
      asel_q <= wr_aggr_sel_i;
    end
  end

  lps_cmd_decode u_dec (
    .cmd_i    (wr_cmd_i),
    .valid_o  (sw_valid),
    .target_o (sw_target)
  );

  lps_idle_detect #(.SLOTS(SLOTS)) u_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .tags_i      (tags_i),
    .idle_fall_o (idle_fall)
  );

  // same-state writes and reserved codes start nothing; software beats auto
  assign sw_go       = wr_en_i & sw_valid & (sw_target != cur_st);
  assign auto_target = asel_q ? LS_SLUMBER : LS_PARTIAL;
  assign auto_go     = idle_fall & aen_q & (cur_st == LS_ACTIVE) & ~sw_go;
  assign go          = sw_go | auto_go;
  assign go_target   = sw_go ? sw_target : auto_target;

  lps_link_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .go_target_i (go_target),
    .ack_i       (link_ack_i),
    .nak_i       (link_nak_i),
    .cmd_o       (cmd_o),
    .req_o       (link_req_o),
    .req_state_o (req_st),
    .state_o     (cur_st)
  );

  assign link_req_state_o = req_st;
  assign link_state_o     = cur_st;
  assign aggr_en_o        = aen_q;
  assign aggr_sel_o       = asel_q;

  a_r7_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sw_valid && cmd_o == CMD_IDLE && !idle_fall) |=> cmd_o == CMD_IDLE);
  a_r8_busy_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_req_o && !link_ack_i && !link_nak_i) |=> $stable(cmd_o));
  a_r10_no_auto_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_req_o && !aggr_en_o && !wr_en_i) |=> !link_req_o);
  a_r6_same_state_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_req_o && wr_en_i && sw_valid && sw_target == cur_st && !idle_fall)
      |=> !link_req_o);
endmodule

// File: tb/sim_lps_ctrl.sv
module sim_lps_ctrl;
  localparam int unsigned SLOTS = 4;

  typedef struct packed {
    logic [3:0] cmd;
    logic       req;
    logic [1:0] rs;
    logic [1:0] st;
    logic       aen;
    logic       asel;
  } snap_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, aen_w = 1'b0, asel_w = 1'b0, ack = 1'b0, nak = 1'b0;
  logic [3:0] wr_cmd = 4'h0;
  logic [SLOTS-1:0] issue = '0, tags = '0;
  logic [3:0] cmd;
  logic aen, asel, req;
  logic [1:0] rs, st;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  snap_t exp_q[$];
  int    rid_q[$];

  always #2 clk = ~clk;

  lps_ctrl #(.SLOTS(SLOTS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_aggr_en_i(aen_w), .wr_aggr_sel_i(asel_w), .cmd_o(cmd),
    .aggr_en_o(aen), .aggr_sel_o(asel), .issue_i(issue), .tags_i(tags),
    .link_req_o(req), .link_req_state_o(rs), .link_ack_i(ack),
    .link_nak_i(nak), .link_state_o(st)
  );

  function automatic snap_t actual();
    snap_t a;
    a = '{cmd: cmd, req: req, rs: rs, st: st, aen: aen, asel: asel};
    return a;
  endfunction

  function automatic void compare(int r, snap_t e);
    snap_t a;
    a = actual();
    if (!e.req) a.rs = e.rs;  // target is don't-care without a request
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL R%0d: actual cmd=%h req=%b rs=%h st=%h aen=%b asel=%b expected cmd=%h req=%b rs=%h st=%h aen=%b asel=%b",
               r, a.cmd, a.req, a.rs, a.st, a.aen, a.asel,
               e.cmd, e.req, e.rs, e.st, e.aen, e.asel);
    end
  endfunction

  // monitor: compare one queued expectation after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(rid_q.pop_front(), exp_q.pop_front());
  end

  // driver: apply inputs at negedge, queue the state expected after next edge
  task automatic cyc(input logic w, input logic [3:0] c, input logic ae, input logic as_,
                     input logic [SLOTS-1:0] is, input logic [SLOTS-1:0] tg,
                     input logic a, input logic n, input int r,
                     input logic [3:0] ec, input logic er, input logic [1:0] ers,
                     input logic [1:0] est, input logic eae, input logic eas);
    snap_t e;
    wr_en = w; wr_cmd = c; aen_w = ae; asel_w = as_;
    issue = is; tags = tg; ack = a; nak = n;
    e = '{cmd: ec, req: er, rs: ers, st: est, aen: eae, asel: eas};
    exp_q.push_back(e);
    rid_q.push_back(r);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(1, '0);                                  // R1 during reset
    rst_n = 1'b1;
    cyc(0,0,0,0, 0,0, 0,0, 1,  0,0,0,0, 0,0);        // R1 after release
    cyc(1,2,0,0, 0,0, 0,0, 2,  2,1,1,0, 0,0);        // R2 partial request
    cyc(0,0,0,0, 0,0, 0,0, 3,  2,1,1,0, 0,0);        // R3 held
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,1, 0,0);        // R4 ack -> partial
    cyc(1,2,0,0, 0,0, 0,0, 6,  0,0,0,1, 0,0);        // R6 already partial
    cyc(1,1,0,0, 0,0, 0,0, 12, 1,1,0,1, 0,0);        // R12 wake
    cyc(1,6,0,0, 0,0, 0,0, 8,  1,1,0,1, 0,0);        // R8 write while busy
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,0, 0,0);        // R4 ack -> active
    cyc(1,6,0,0, 0,0, 0,0, 2,  6,1,2,0, 0,0);        // R2 slumber request
    cyc(0,0,0,0, 0,0, 0,1, 5,  0,0,0,0, 0,0);        // R5 reject
    cyc(1,5,0,0, 0,0, 0,0, 7,  0,0,0,0, 0,0);        // R7
    cyc(1,4'hF,0,0, 0,0, 0,0, 7, 0,0,0,0, 0,0);      // R7
    cyc(1,3,0,0, 0,0, 0,0, 7,  0,0,0,0, 0,0);        // R7
    cyc(1,0,1,1, 0,0, 0,0, 9,  0,0,0,0, 1,1);        // R9 enable, slumber
    cyc(0,0,0,0, 1,0, 0,0, 9,  0,0,0,0, 1,1);
    cyc(0,0,0,0, 0,2, 0,0, 9,  0,0,0,0, 1,1);        // tags keep it busy
    cyc(0,0,0,0, 0,0, 0,0, 9,  6,1,2,0, 1,1);        // R9 auto slumber
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,2, 1,1);
    cyc(0,0,0,0, 0,0, 0,0, 11, 0,0,0,2, 1,1);        // R11 no repeat
    cyc(0,0,0,0, 1,0, 0,0, 11, 0,0,0,2, 1,1);
    cyc(0,0,0,0, 0,0, 0,0, 11, 0,0,0,2, 1,1);        // R11 not from slumber
    cyc(1,1,1,1, 0,0, 0,0, 12, 1,1,0,2, 1,1);        // R12 wake from slumber
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,0, 1,1);
    cyc(1,0,1,0, 0,0, 0,0, 8,  0,0,0,0, 1,0);        // R8 bits update
    cyc(0,0,0,0, 4'h3,0, 0,0, 9, 0,0,0,0, 1,0);
    cyc(0,0,0,0, 0,0, 0,0, 9,  2,1,1,0, 1,0);        // R9 auto partial
    cyc(0,0,0,0, 0,0, 0,1, 5,  0,0,0,0, 1,0);
    cyc(0,0,0,0, 0,0, 0,0, 11, 0,0,0,0, 1,0);        // R11 once only
    cyc(0,0,0,0, 1,0, 0,0, 11, 0,0,0,0, 1,0);
    cyc(1,6,1,0, 0,0, 0,0, 11, 6,1,2,0, 1,0);        // R11 software wins
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,2, 1,0);
    cyc(1,1,1,0, 0,0, 0,0, 12, 1,1,0,2, 1,0);
    cyc(0,0,0,0, 0,0, 1,0, 4,  0,0,0,0, 1,0);
    cyc(1,0,0,0, 0,0, 0,0, 10, 0,0,0,0, 0,0);        // R10 disable
    cyc(0,0,0,0, 0,1, 0,0, 10, 0,0,0,0, 0,0);
    cyc(0,0,0,0, 0,0, 0,0, 10, 0,0,0,0, 0,0);        // R10 no auto
    cyc(0,0,0,0, 0,0, 0,0, 10, 0,0,0,0, 0,0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule